// File: doc/BRIEF.md
# Bus Timeout Monitor with Write-Once Control Register

This block guards bus cycles that an internal master sends to the external bus. When such a cycle starts, a timer is armed. If no transfer acknowledge arrives before the programmed limit, the block raises a single-clock transfer-error pulse. The timer resolution is eight clocks: a divide-by-8 prescaler drives an 8-bit interval counter. The monitor can be switched off. While it is off, an expired cycle raises no error.

The block also holds a 32-bit protection control register. It carries the monitor's limit and enable, plus a set of watchdog fields that are only stored and read back here. The register can be read at any moment. After reset it accepts exactly one write; from then on it is frozen until the next reset.

Top module: `busTimeoutMonitor`

## Requirements
- R1: Out of reset the register reads 32'hFFFF_000F and xferErr is 0.
- R2: regRdData always shows the current register contents, combinationally, with no read strobe.
- R3: The first cycle with regWrEn=1 after reset loads the register. Every later write has no effect on regRdData until the next reset.
- R4: Bit layout: [31:16] watchdog count, [15:8] timeout field T, [7] monitor enable, [6:4] reserved, [3:0] watchdog controls. The reserved bits always read 0; all other bits read back as written.
- R5: Suppose a monitored start is sampled at a clock edge, and no acknowledge or new start follows. Then xferErr is 1 for exactly the one cycle after the (8*T)-th edge following the start edge.
- R6: T=0 behaves as T=1, giving 8 clocks. T=255 gives the longest limit of 2040 clocks.
- R7: An acknowledge sampled at any edge after the start, up to and including the expiry edge, ends the cycle with no error.
- R8: With the enable bit at 0, xferErr never rises.
- R9: A start is monitored only when cycToExt=1. A start with cycToExt=0 neither arms the timer nor disturbs a pending cycle.
- R10: A new monitored start while a cycle is pending restarts the full limit from that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register contents |
| cycStart | input | 1 | Bus cycle start, one clock |
| cycToExt | input | 1 | Qualifies cycStart: the cycle goes from the internal side to the external bus |
| cycAck | input | 1 | Transfer acknowledge |
| xferErr | output | 1 | Transfer-error pulse on timeout |

## Verification
Each reset draws a random register image, so the limit, the enable bit and the watchdog bits vary from run to run. Each configuration then runs several cycles with a random direction and a random acknowledge time. The acknowledge may come early, exactly on the expiry edge, one edge too late, or never; this separates an off-by-one error in the prescaler or counter from a correct limit. Directed cases cover the limit extremes (T=0 and T=255), a restart in mid-cycle, and an unqualified start in mid-cycle. Together they show whether the timer restarts or ignores such a start. A second write carrying different data is read back to show whether the lock holds.

// File: rtl/btm_pkg.sv
package btm_pkg;
  localparam int RegW      = 32;
  localparam int TimeLsb   = 8;
  localparam int EnBit     = 7;
  localparam logic [RegW-1:0] CfgReset = 32'hFFFF_000F;
  localparam logic [RegW-1:0] RsvdMask = 32'h0000_0070;

  typedef struct packed {
    logic loadCfg;
    logic clrTimer;
    logic runTimer;
  } strobe_t;
endpackage

// File: rtl/btm_datapath.sv
module btm_datapath
  import btm_pkg::*;
#(
  parameter int PreW  = 3,
  parameter int TimeW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [RegW-1:0] wrData,
  output logic [RegW-1:0] rdData,
  output logic            cfgEnable,
  output logic            expire
);
  logic [RegW-1:0]  cfgQ;
  logic [PreW-1:0]  preQ;
  logic [TimeW-1:0] cntQ;
  logic [TimeW-1:0] timeField;
  logic [TimeW-1:0] limit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= CfgReset;
    end else if (stb.loadCfg) begin
      cfgQ <= wrData & ~RsvdMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrTimer) begin
      preQ <= '0;
      cntQ <= '0;
    end else if (stb.runTimer) begin
      preQ <= preQ + 1'b1;
      if (&preQ) cntQ <= cntQ + 1'b1;
    end
  end

  assign timeField = cfgQ[TimeLsb +: TimeW];
  assign limit     = (timeField == '0) ? TimeW'(1) : timeField;
  assign expire    = (&preQ) && (cntQ == limit - 1'b1);
  assign cfgEnable = cfgQ[EnBit];
  assign rdData    = cfgQ;

  // R4: reserved bits never hold a one
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & RsvdMask) == '0);
  // R6: while running, the interval count stays below the limit
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    stb.runTimer |-> (cntQ < limit));
endmodule

// File: rtl/btm_ctrl.sv
module btm_ctrl
  import btm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    regWrEn,
  input  logic    cycStart,
  input  logic    cycToExt,
  input  logic    cycAck,
  input  logic    cfgEnable,
  input  logic    expire,
  output strobe_t stb,
  output logic    locked,
  output logic    xferErr
);
  logic activeQ;
  logic errQ;
  logic lockQ;
  logic monStart;

  assign monStart = cycStart && cycToExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      errQ    <= 1'b0;
      lockQ   <= 1'b0;
    end else begin
      errQ  <= 1'b0;
      lockQ <= lockQ | regWrEn;
      if (monStart) begin
        activeQ <= 1'b1;
      end else if (activeQ) begin
        if (cycAck) begin
          activeQ <= 1'b0;
        end else if (expire) begin
          activeQ <= 1'b0;
          errQ    <= cfgEnable;
        end
      end
    end
  end

  assign stb.loadCfg  = regWrEn && !lockQ;
  assign stb.clrTimer = monStart;
  assign stb.runTimer = activeQ;
  assign locked       = lockQ;
  assign xferErr      = errQ;

  // R5: the error is a single-clock pulse
  a_r5_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    xferErr |=> !xferErr);
  // R8: an error is only raised with the monitor enabled
  a_r8_gated: assert property (@(posedge clk) disable iff (!rstN)
    xferErr |-> $past(cfgEnable));
  // R7: an acknowledge on a pending cycle suppresses the error
  a_r7_ack_clean: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && cycAck && !monStart) |=> !xferErr);
  // R9: an unqualified start on an idle monitor leaves it idle
  a_r9_ext_only: assert property (@(posedge clk) disable iff (!rstN)
    (cycStart && !cycToExt && !activeQ) |=> !activeQ);
endmodule

// File: rtl/busTimeoutMonitor.sv
module busTimeoutMonitor
  import btm_pkg::*;
#(
  parameter int PreW  = 3,
  parameter int TimeW = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        cycStart,
  input  logic        cycToExt,
  input  logic        cycAck,
  output logic        xferErr
);
  strobe_t stb;
  logic    cfgEnable;
  logic    expire;
  logic    locked;

  btm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn),
    .cycStart(cycStart), .cycToExt(cycToExt), .cycAck(cycAck),
    .cfgEnable(cfgEnable), .expire(expire),
    .stb(stb), .locked(locked), .xferErr(xferErr)
  );

  btm_datapath #(.PreW(PreW), .TimeW(TimeW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData),
    .rdData(regRdData), .cfgEnable(cfgEnable), .expire(expire)
  );

  // R3: once locked, the register contents never change
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(regRdData));
endmodule

// File: tb/busTimeoutMonitor_tb.sv
`timescale 1ns/1ps
module busTimeoutMonitor_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        cycStart = 1'b0;
  logic        cycToExt = 1'b0;
  logic        cycAck = 1'b0;
  logic        xferErr;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  busTimeoutMonitor u_dut (.*);

  function automatic int limitOf(logic [31:0] cfg);
    int t = int'(cfg[15:8]);
    return (t == 0) ? 8 : t * 8;
  endfunction

  function automatic logic [31:0] stored(logic [31:0] d);
    return d & ~32'h0000_0070;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWrEn = 1'b0; cycStart = 1'b0; cycAck = 1'b0; cycToExt = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // start at edge 0; optional second start at edge rs (qualified if rsExt); ack at edge ackAt
  task automatic trial(string tag, logic [31:0] cfg, logic toExt, int ackAt, int rs, logic rsExt);
    int n = limitOf(cfg);
    int s = (rs != 0 && rsExt) ? rs : 0;
    logic armed = toExt || (s != 0);
    int errK = s + n;
    logic fire = cfg[7] && armed && !(ackAt > s && ackAt <= errK);
    @(negedge clk);
    cycStart = 1'b1; cycToExt = toExt;
    @(posedge clk);
    for (int k = 1; k <= errK + 2; k++) begin
      @(negedge clk);
      cycStart = (k == rs); cycToExt = (k == rs) ? rsExt : 1'b0;
      cycAck = (k == ackAt);
      @(posedge clk);
      #1;
      chk(tag, {31'd0, xferErr}, {31'd0, fire && (k == errK)});
    end
    @(negedge clk);
    cycStart = 1'b0; cycAck = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] cfg;
    void'($urandom(32'h5EED_0017));

    // R1 reset values
    doReset();
    #1;
    chk("R1 reset reg", regRdData, 32'hFFFF_000F);
    chk("R1 reset err", {31'd0, xferErr}, 32'd0);

    // R2/R4 readback, R3 lock
    cfg = 32'hA5C3_0BFF;
    wr(cfg);
    #1;
    chk("R4 layout readback", regRdData, stored(cfg));
    chk("R2 read any time", regRdData, 32'hA5C3_0B8F);
    wr(32'h1234_5678);
    #1;
    chk("R3 second write ignored", regRdData, stored(cfg));

    // R6 minimum: T=0 -> 8 clocks; R7 ack exactly at expiry edge; ack one late
    doReset();
    cfg = 32'h0000_0080;
    wr(cfg);
    trial("R6 T=0 limit 8", cfg, 1'b1, 0, 0, 1'b0);
    trial("R7 ack at expiry edge", cfg, 1'b1, 8, 0, 1'b0);
    trial("R7 ack one edge late", cfg, 1'b1, 9, 0, 1'b0);
    trial("R7 early ack", cfg, 1'b1, 1, 0, 1'b0);

    // R6 maximum: T=255 -> 2040 clocks
    doReset();
    cfg = 32'h0000_FF80;
    wr(cfg);
    trial("R6 T=255 limit 2040", cfg, 1'b1, 0, 0, 1'b0);

    // R10 restart, R9 unqualified start mid-cycle
    doReset();
    cfg = 32'h0000_0280;
    wr(cfg);
    trial("R10 restart mid-cycle", cfg, 1'b1, 0, 6, 1'b1);
    trial("R9 unqualified start mid-cycle", cfg, 1'b1, 0, 6, 1'b0);
    trial("R9 unqualified start idle", cfg, 1'b0, 0, 0, 1'b0);

    // R8 disabled
    doReset();
    cfg = 32'hFFFF_037F;
    wr(cfg);
    trial("R8 disabled no error", cfg, 1'b1, 0, 0, 1'b0);

    // random configurations and cycles
    for (int r = 0; r < 16; r++) begin
      doReset();
      cfg = $urandom;
      cfg[15:8] = 8'($urandom % 24);
      cfg[7] = ($urandom % 4) != 0;
      wr(cfg);
      #1;
      chk("R4 random readback", regRdData, stored(cfg));
      wr($urandom);
      #1;
      chk("R3 random relock", regRdData, stored(cfg));
      for (int t = 0; t < 4; t++) begin
        int n = limitOf(cfg);
        int a = ($urandom % 3 == 0) ? 0 : int'($urandom % (n + 3)) + 1;
        trial("R5 random cycle", cfg, ($urandom % 5) != 0, a, 0, 1'b0);
      end
    end

    summary();
  end
endmodule